// File: doc/BRIEF.md
# Write-Through Data Cache with Posted-Write Queue

This block is a direct-mapped data cache that sits between a requester and a slower main memory and keeps memory current on every store. Loads that find their word in the cache finish in the cycle they are presented, and the data comes back one cycle later. A load that misses stalls the requester and fetches the word from memory. The word, its tag and its valid flag are then installed, and the held load is accepted on the next cycle as a hit.

Stores update the cache line in every case. On a miss the line is taken over, with its tag rewritten and its valid flag set. Each store is also posted into a FIFO of address/data pairs, so the requester moves on without waiting for memory. The FIFO drains to memory in arrival order over its own channel, with one write outstanding at a time. An entry leaves the FIFO only when memory pulses a completion. A store meets back-pressure only when the FIFO is full. A load miss whose word is still waiting in the FIFO does not read memory until that entry has completed.

All three request channels use valid/ready. A source raises valid and must hold valid and its payload unchanged until it sees ready high at a rising edge. The block never withdraws `mem_rd_valid` or `mem_wr_valid` before it is accepted. Read data from memory (`mem_rd_rvalid`) and write completions (`mem_wr_done`) are single-cycle pulses that cannot be back-pressured.

Top module: `wt_dcache`

## Requirements
- R1: Directly after reset, every line is invalid, the write FIFO is empty, and `mem_rd_valid`, `mem_wr_valid` and `cpu_rsp_valid` are low.
- R2: A load whose line is valid and whose tag matches has `cpu_req_ready` high in the cycle it is presented. `cpu_rsp_valid` is high for exactly the next cycle, carrying the stored word.
- R3: A load that misses holds `cpu_req_ready` low and issues one memory read with a word-aligned address, meaning address bits [1:0] are 0. Address bits [1:0] are the byte offset, the next log2(LINES) bits are the line index, and the remaining upper bits are the tag.
- R4: In the cycle after `mem_rd_rvalid`, the held load is accepted as a hit and returns the refilled word. With a read latency of L cycles after the read handshake, the load waits 2+L cycles.
- R5: A store presented while the FIFO is not full is accepted in the same cycle. The line is written even on a miss, so a later load of that word hits and returns the stored data without reading memory.
- R6: Every accepted store appears on the memory write channel with its full address and data, in the order the stores were accepted. Memory holds the stored data once the completion has been seen.
- R7: A FIFO entry is released only by a `mem_wr_done` pulse. Until then, no further write is offered on the memory write channel.
- R8: With WB_DEPTH entries held, a store keeps `cpu_req_ready` low until a completion frees an entry. The FIFO never holds more than WB_DEPTH entries.
- R9: A load miss whose word address equals a held FIFO entry raises no `mem_rd_valid` until that entry has been released.
- R10: While a refill is outstanding, `cpu_req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Requester has a load or store |
| cpu_req_ready | output | 1 | Request accepted at this edge |
| cpu_req_we | input | 1 | 1 for store, 0 for load |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | Load data valid, one cycle after acceptance |
| cpu_rsp_rdata | output | DATA_W | Load data |
| mem_rd_valid | output | 1 | Refill read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | ADDR_W | Word-aligned refill address |
| mem_rd_rvalid | input | 1 | Refill data pulse |
| mem_rd_rdata | input | DATA_W | Refill data |
| mem_wr_valid | output | 1 | FIFO head offered to memory |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_data | output | DATA_W | Write data |
| mem_wr_done | input | 1 | Memory completed the outstanding write |

## Verification
A corrupted tag or valid flag shows up at the requester port on the very next load to that line. The symptom is either an unexpected memory read or `cpu_req_ready` coming back high without one, so the bench counts memory reads for every load. A FIFO pointer or count error appears on the memory write channel as a wrong, repeated or reordered address/data pair within one drain. Premature release or a missed hazard appears a few cycles later: a second write is offered before completion, or a refill read is issued while the matching store is still held. The bench exposes both by holding completions back for many cycles.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_RDREQ = 2'd1,
    CS_RDWAIT = 2'd2
  } ctrl_state_t;
endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
  parameter int WA_W   = 30,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WA_W-1:0]   lk_waddr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              wr_en,
  input  logic [WA_W-1:0]   wr_waddr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = WA_W - IDX_W;

  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] word_q [LINES];
  logic [LINES-1:0]  vld_q;

  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [TAG_W-1:0] lk_tag, wr_tag;

  assign lk_idx = lk_waddr[IDX_W-1:0];
  assign lk_tag = lk_waddr[WA_W-1:IDX_W];
  assign wr_idx = wr_waddr[IDX_W-1:0];
  assign wr_tag = wr_waddr[WA_W-1:IDX_W];

  assign lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_data = word_q[lk_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      word_q[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [ADDR_W-1:0]        push_addr,
  input  logic [DATA_W-1:0]        push_data,
  output logic                     full,
  output logic [$clog2(DEPTH):0]   count,
  input  logic [ADDR_W-3:0]        probe_waddr,
  output logic                     probe_match,
  output logic                     mem_wr_valid,
  input  logic                     mem_wr_ready,
  output logic [ADDR_W-1:0]        mem_wr_addr,
  output logic [DATA_W-1:0]        mem_wr_data,
  input  logic                     mem_wr_done
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              issued_q;
  logic              pop;
  logic [DEPTH-1:0]  match_vec;

  assign pop          = mem_wr_done && issued_q;
  assign full         = (cnt_q == CNT_W'(DEPTH));
  assign count        = cnt_q;
  assign mem_wr_valid = (cnt_q != '0) && !issued_q;
  assign mem_wr_addr  = addr_q[head_q];
  assign mem_wr_data  = data_q[head_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q   <= '0;
      tail_q   <= '0;
      cnt_q    <= '0;
      issued_q <= 1'b0;
    end else begin
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (pop) begin
        issued_q <= 1'b0;
      end else if (mem_wr_valid && mem_wr_ready) begin
        issued_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_probe
    logic [PTR_W-1:0] rel;
    assign rel = PTR_W'(gi) - head_q;
    assign match_vec[gi] = ({1'b0, rel} < cnt_q) &&
                           (addr_q[gi][ADDR_W-1:2] == probe_waddr);
  end

  assign probe_match = |match_vec;
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req_valid,
  input  logic cpu_req_we,
  input  logic lk_hit,
  input  logic wb_full,
  input  logic wb_match,
  input  logic mem_rd_ready,
  input  logic mem_rd_rvalid,
  output logic cpu_req_ready,
  output logic miss_capture,
  output logic wb_push,
  output logic line_fill,
  output logic rd_fire,
  output logic mem_rd_valid
);
  ctrl_state_t st_q, st_d;

  always_comb begin
    st_d          = st_q;
    cpu_req_ready = 1'b0;
    miss_capture  = 1'b0;
    wb_push       = 1'b0;
    line_fill     = 1'b0;
    rd_fire       = 1'b0;
    mem_rd_valid  = 1'b0;
    unique case (st_q)
      CS_IDLE: begin
        if (cpu_req_valid) begin
          if (cpu_req_we) begin
            cpu_req_ready = !wb_full;
            wb_push       = !wb_full;
          end else if (lk_hit) begin
            cpu_req_ready = 1'b1;
            rd_fire       = 1'b1;
          end else begin
            miss_capture = 1'b1;
            st_d         = CS_RDREQ;
          end
        end
      end
      CS_RDREQ: begin
        mem_rd_valid = !wb_match;
        if (!wb_match && mem_rd_ready) st_d = CS_RDWAIT;
      end
      CS_RDWAIT: begin
        if (mem_rd_rvalid) begin
          line_fill = 1'b1;
          st_d      = CS_IDLE;
        end
      end
      default: st_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= CS_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int LINES    = 16,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_rvalid,
  input  logic [DATA_W-1:0] mem_rd_rdata,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_done
);
  localparam int WA_W  = ADDR_W - 2;
  localparam int CNT_W = $clog2(WB_DEPTH) + 1;

  logic [WA_W-1:0]   cpu_waddr, miss_waddr_q, st_waddr;
  logic [DATA_W-1:0] st_data, lk_data, rdata_q;
  logic              lk_hit, wb_full, wb_match;
  logic              miss_capture, wb_push, line_fill, rd_fire;
  logic              rsp_q;
  logic [CNT_W-1:0]  wb_count;

  assign cpu_waddr = cpu_req_addr[ADDR_W-1:2];
  assign st_waddr  = line_fill ? miss_waddr_q : cpu_waddr;
  assign st_data   = line_fill ? mem_rd_rdata : cpu_req_wdata;

  wtc_line_store #(.WA_W(WA_W), .DATA_W(DATA_W), .LINES(LINES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_waddr (cpu_waddr),
    .lk_hit   (lk_hit),
    .lk_data  (lk_data),
    .wr_en    (line_fill || wb_push),
    .wr_waddr (st_waddr),
    .wr_data  (st_data)
  );

  wtc_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk          (clk),
    .rst_n        (rst_n),
    .push         (wb_push),
    .push_addr    (cpu_req_addr),
    .push_data    (cpu_req_wdata),
    .full         (wb_full),
    .count        (wb_count),
    .probe_waddr  (miss_waddr_q),
    .probe_match  (wb_match),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_done  (mem_wr_done)
  );

  wtc_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_we    (cpu_req_we),
    .lk_hit        (lk_hit),
    .wb_full       (wb_full),
    .wb_match      (wb_match),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_rvalid (mem_rd_rvalid),
    .cpu_req_ready (cpu_req_ready),
    .miss_capture  (miss_capture),
    .wb_push       (wb_push),
    .line_fill     (line_fill),
    .rd_fire       (rd_fire),
    .mem_rd_valid  (mem_rd_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_waddr_q <= '0;
      rsp_q        <= 1'b0;
      rdata_q      <= '0;
    end else begin
      if (miss_capture) miss_waddr_q <= cpu_waddr;
      rsp_q <= rd_fire;
      if (rd_fire) rdata_q <= lk_data;
    end
  end

  assign cpu_rsp_valid = rsp_q;
  assign cpu_rsp_rdata = rdata_q;
  assign mem_rd_addr   = {miss_waddr_q, 2'b00};
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_we,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              mem_rd_valid,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_wr_done,
  input logic [CNT_W-1:0]  wb_count,
  input logic              wb_match
);
  AST_RSP_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> $past(cpu_req_valid && cpu_req_ready && !cpu_req_we)); // R2
  AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (mem_rd_addr[1:0] == 2'b00)); // R3
  AST_FREE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_count < $past(wb_count)) |-> $past(mem_wr_done)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wb_count <= CNT_W'(DEPTH)); // R8
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_we && wb_count == CNT_W'(DEPTH)) |-> !cpu_req_ready); // R8
  AST_NO_RAW_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !wb_match); // R9
  AST_REFILL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !cpu_req_ready); // R10
endmodule

bind wt_dcache wtc_checker #(
  .ADDR_W (ADDR_W),
  .DEPTH  (WB_DEPTH),
  .CNT_W  ($clog2(WB_DEPTH) + 1)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_we    (cpu_req_we),
  .cpu_req_ready (cpu_req_ready),
  .cpu_rsp_valid (cpu_rsp_valid),
  .mem_rd_valid  (mem_rd_valid),
  .mem_rd_addr   (mem_rd_addr),
  .mem_wr_done   (mem_wr_done),
  .wb_count      (wb_count),
  .wb_match      (wb_match)
);

// File: tb/tb_wt_dcache.sv
module tb_wt_dcache;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic mem_rd_valid, mem_rd_ready = 1'b0, mem_rd_rvalid = 1'b0;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_rdata = '0;
  logic mem_wr_valid, mem_wr_ready = 1'b0, mem_wr_done = 1'b0;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;

  always #10 clk = ~clk;

  wt_dcache dut (.*);

  int checks = 0, fails = 0;
  int mem_reads = 0, wr_done_cnt = 0;
  int rd_lat = 1, wr_lat = 1;
  bit wr_hold = 1'b0;
  logic [DW-1:0] model [256];
  logic [AW+DW-1:0] exp_wr [$];

  function automatic logic [DW-1:0] init_val(int w);
    return 32'hC0DE_0000 ^ (32'(w) * 32'h0001_0011);
  endfunction

  function automatic logic [DW-1:0] st_val(int w);
    return 32'h5A00_0000 + 32'(w) * 32'h0000_0101;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // memory read responder
  initial begin
    @(negedge clk);
    forever begin
      if (mem_rd_valid) begin
        mem_reads++;
        mem_rd_ready = 1'b1;
        @(posedge clk);
        mem_rd_ready <= 1'b0;
        for (int k = 0; k < rd_lat; k++) @(negedge clk);
        mem_rd_rvalid = 1'b1;
        mem_rd_rdata = model[mem_rd_addr[9:2]];
        @(negedge clk);
        mem_rd_rvalid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  // memory write responder
  initial begin
    @(negedge clk);
    forever begin
      if (mem_wr_valid) begin
        logic [AW+DW-1:0] e;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        a = mem_wr_addr;
        d = mem_wr_data;
        if (exp_wr.size() == 0) begin
          chk(1'b0, "R6 unexpected write", {a, d}, 64'h0);
        end else begin
          e = exp_wr.pop_front();
          chk({a, d} == e, "R6 write order/content", {a, d}, e);
        end
        mem_wr_ready = 1'b1;
        @(posedge clk);
        mem_wr_ready <= 1'b0;
        @(negedge clk);
        while (wr_hold) begin
          chk(!mem_wr_valid, "R7 second write offered before done", 64'(mem_wr_valid), 64'h0);
          @(negedge clk);
        end
        for (int k = 1; k < wr_lat; k++) @(negedge clk);
        mem_wr_done = 1'b1;
        model[a[9:2]] = d;
        wr_done_cnt++;
        @(negedge clk);
        mem_wr_done = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic do_read(input int w, output logic [DW-1:0] data, output int stall, output int nrd);
    int r0;
    r0 = mem_reads;
    stall = 0;
    cpu_req_valid = 1'b1;
    cpu_req_we = 1'b0;
    cpu_req_addr = AW'(w) << 2;
    #1;
    while (!cpu_req_ready) begin
      @(negedge clk);
      stall++;
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    chk(cpu_rsp_valid, "R2 response valid", 64'(cpu_rsp_valid), 64'h1);
    data = cpu_rsp_rdata;
    nrd = mem_reads - r0;
    @(negedge clk);
    chk(!cpu_rsp_valid, "R2 response one cycle", 64'(cpu_rsp_valid), 64'h0);
  endtask

  task automatic do_write(input int w, input logic [DW-1:0] d, output int stall);
    stall = 0;
    cpu_req_valid = 1'b1;
    cpu_req_we = 1'b1;
    cpu_req_addr = AW'(w) << 2;
    cpu_req_wdata = d;
    #1;
    while (!cpu_req_ready) begin
      @(negedge clk);
      stall++;
      #1;
    end
    exp_wr.push_back({AW'(w) << 2, d});
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    cpu_req_we = 1'b0;
  endtask

  task automatic wait_drain(input int target);
    while (wr_done_cnt < target) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'h0, 64'h1);
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    int st, nr, wtot;
    for (int i = 0; i < 256; i++) model[i] = init_val(i);
    wtot = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!mem_rd_valid, "R1 rd idle", 64'(mem_rd_valid), 64'h0);
    chk(!mem_wr_valid, "R1 wr idle", 64'(mem_wr_valid), 64'h0);
    chk(!cpu_rsp_valid, "R1 rsp idle", 64'(cpu_rsp_valid), 64'h0);

    // R3/R4/R10: cold miss then hit on every line, varying read latency
    for (int w = 0; w < 16; w++) begin
      rd_lat = (w % 3) + 1;
      do_read(w, d, st, nr);
      chk(d == model[w], "R4 refill data", d, model[w]);
      chk(nr == 1, "R3 one read per miss", nr, 1);
      chk(st == 2 + rd_lat, "R4 R10 miss stall cycles", st, 2 + rd_lat);
      do_read(w, d, st, nr);
      chk(d == model[w] && nr == 0 && st == 0, "R2 hit", {d, 32'(nr)}, {model[w], 32'h0});
    end
    rd_lat = 1;
    // R3: conflict misses replace tag
    for (int w = 0; w < 16; w++) begin
      do_read(w + 16, d, st, nr);
      chk(d == model[w + 16] && nr == 1, "R3 conflict miss", {d, 32'(nr)}, {model[w + 16], 32'h1});
      do_read(w, d, st, nr);
      chk(nr == 1, "R3 evicted line misses", nr, 1);
    end

    // R5/R6: stores allocate and drain in order
    wr_lat = 2;
    for (int w = 0; w < 16; w++) begin
      do_write(w + 32, st_val(w), st);
      wtot++;
    end
    chk(1'b1, "R5 stores accepted", 0, 0);
    for (int w = 0; w < 16; w++) begin
      do_read(w + 32, d, st, nr);
      chk(d == st_val(w) && nr == 0, "R5 store allocates line", {d, 32'(nr)}, {st_val(w), 32'h0});
    end
    wait_drain(wtot);
    chk(exp_wr.size() == 0, "R6 all stores drained", exp_wr.size(), 0);
    for (int w = 0; w < 16; w++) begin
      do_read(w + 48, d, st, nr);
      do_read(w + 32, d, st, nr);
      chk(d == st_val(w) && nr == 1, "R6 memory updated", {d, 32'(nr)}, {st_val(w), 32'h1});
    end

    // R7/R8: full FIFO stalls stores until a completion
    wr_lat = 1;
    wr_hold = 1'b1;
    for (int w = 0; w < DEPTH; w++) begin
      do_write(w + 64, st_val(w + 64), st);
      chk(st == 0, "R5 store not stalled when not full", st, 0);
      wtot++;
    end
    fork
      begin
        do_write(100, st_val(100), st);
        wtot++;
      end
      begin
        repeat (6) @(negedge clk);
        #1;
        chk(!cpu_req_ready, "R8 full stalls store", 64'(cpu_req_ready), 64'h0);
        chk(!mem_wr_valid, "R7 held entry blocks next write", 64'(mem_wr_valid), 64'h0);
        wr_hold = 1'b0;
      end
    join
    chk(st >= 6, "R8 stall length", st, 6);
    wait_drain(wtot);

    // R9: load miss to a word still in the FIFO
    wr_hold = 1'b1;
    do_write(5, 32'hDEAD_0005, st);
    do_write(21, 32'hBEEF_0015, st);
    wtot += 2;
    fork
      begin
        do_read(5, d, st, nr);
      end
      begin
        int r0;
        r0 = mem_reads;
        repeat (8) @(negedge clk);
        chk(mem_reads == r0 && !mem_rd_valid, "R9 no read while store held", mem_reads - r0, 0);
        wr_hold = 1'b0;
      end
    join
    chk(d == 32'hDEAD_0005 && nr == 1, "R9 read returns drained store", {d, 32'(nr)}, {32'hDEAD_0005, 32'h1});
    wait_drain(wtot);
    chk(exp_wr.size() == 0, "R6 final drain", exp_wr.size(), 0);
    finish_run();
  end
endmodule